// File: doc/BRIEF.md
# PCIe Root-Port Interrupt Aggregator

This block gathers the two interrupt styles a PCIe root complex receives and drives one level-sensitive host interrupt line from them. The first style is the four legacy INTx wires, which are level signals. The second is message-signalled interrupts, where an endpoint's MSI write carries a vector number as its data. Each vector number is recorded as one bit in a bank of 32-bit status words. Software reads and updates the enable and status state through a small register port, one access per cycle.

The host line is held by a two-state machine. In `LINE_LOW` the line is deasserted. It moves to `LINE_HIGH` on an accepted MSI, or on an INTx edge while an enabled status bit is active. In `LINE_HIGH` it stays high on an accepted MSI. It falls to `LINE_LOW` on a servicing clear that leaves every MSI word empty, or on an INTx edge after which no enabled status bit remains. In every other cycle the state is held.

When several events fall in the same cycle, they are ranked: an accepted MSI first, then a servicing clear that empties the words, then the INTx evaluation. A clear of all ones counts as initialisation, not as servicing, so it leaves the line alone. The line is therefore event-driven and does not simply reflect the status registers.

Top module: `pcie_irq_aggr`

## Requirements
- R1: An MSI write whose data is 0 to 31 sets that bit of MSI word 0 (register address 2) one cycle later.
- R2: An MSI write whose data is 32 to 63 sets bit (data minus 32) of MSI word 1 (register address 3) one cycle later.
- R3: Every accepted MSI write makes `irq` high one cycle later, whatever else happens in that cycle.
- R4: A write to an MSI word clears the bits that are set in the write data. A write of zero changes neither the word nor `irq`.
- R5: A write of 0xFFFFFFFF to an MSI word clears the whole word and leaves `irq` unchanged.
- R6: Any other nonzero write to an MSI word lowers `irq` only when all MSI words are zero afterwards. Otherwise `irq` is unchanged.
- R7: Bits 3:0 of the INTx status register (address 1) equal `intx_pin[3:0]` as sampled at the previous clock edge.
- R8: When any INTx pin differs from its status bit, `irq` becomes the OR of (next status AND next enable) over bits 4:0. The enable register is at address 0, bits 4:0. Writing the enable register without an INTx edge leaves `irq` unchanged.
- R9: Software writes to the INTx status register never alter bits 3:0. A `txn_done` pulse sets bit 4. Writing 1 to bit 4 clears it, and a set in the same cycle wins over the clear.
- R10: MSI data of 64 or above sets no status bit and pulses `msi_err` high for one cycle, one cycle after the write.
- R11: After reset, every register reads zero, and `irq` and `msi_err` are low.
- R12: Same-cycle priority: an MSI bit set wins over a clear of the same word, and an accepted MSI wins over lowering `irq`. A servicing clear that empties the words wins over an INTx evaluation. Register bits above the defined fields read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| intx_pin | input | 4 | Legacy interrupt pin levels |
| txn_done | input | 1 | Pulse that sets the transaction-done flag |
| msi_valid | input | 1 | MSI write strobe |
| msi_data | input | 32 | MSI write data (vector number) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 enable, 1 INTx status, 2 and 3 MSI words |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| irq | output | 1 | Host interrupt level |
| msi_err | output | 1 | One-cycle flag for an out-of-range MSI vector |

## Verification
The bench builds the block with its default of 64 vectors, which gives two status words and a 2-bit register address. Random MSI data is drawn from 0 to 79, so in-range writes to both words and dropped writes are both exercised. Clear masks are biased toward zero, all ones and single bits. This brings the initialisation path, the empty-after-servicing path and same-cycle collisions with INTx edges within reach.

// File: rtl/pcie_irq_pkg.sv
package pcie_irq_pkg;
    localparam int unsigned WORD_W    = 32;
    localparam int unsigned INTX_PINS = 4;
    localparam int unsigned ISTS_W    = INTX_PINS + 1;

    typedef enum logic [0:0] {
        LINE_LOW  = 1'b0,
        LINE_HIGH = 1'b1
    } line_state_e;
endpackage

// File: rtl/pcie_irq_msi_bank.sv
module pcie_irq_msi_bank
    import pcie_irq_pkg::*;
#(
    parameter int unsigned NUM_VEC = 64,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned REG_AW  = 2,
    parameter int unsigned BASE    = 2,
    localparam int unsigned NUM_WORDS = NUM_VEC / WORD_W,
    localparam int unsigned VEC_W     = $clog2(NUM_VEC)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        msi_valid,
    input  logic [DATA_W-1:0]           msi_data,
    input  logic                        reg_wr,
    input  logic [REG_AW-1:0]           reg_addr,
    input  logic [WORD_W-1:0]           reg_wdata,
    output logic [NUM_WORDS*WORD_W-1:0] words_o,
    output logic                        hit_o,
    output logic                        drop_o,
    output logic                        serviced_empty_o
);
    logic [VEC_W-1:0]            vec_idx;
    logic [NUM_WORDS*WORD_W-1:0] words_nxt;
    logic [NUM_WORDS-1:0]        svc_w;

    assign vec_idx = msi_data[VEC_W-1:0];
    assign hit_o   = msi_valid && (msi_data <  DATA_W'(NUM_VEC));
    assign drop_o  = msi_valid && (msi_data >= DATA_W'(NUM_VEC));

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        logic              sel;
        logic [WORD_W-1:0] clr_mask;
        logic [WORD_W-1:0] set_mask;

        assign sel      = reg_wr && (reg_addr == REG_AW'(BASE + w));
        assign clr_mask = sel ? reg_wdata : '0;
        assign set_mask = (hit_o && ((vec_idx >> 5) == VEC_W'(w)))
                          ? (WORD_W'(1) << vec_idx[4:0]) : '0;
        assign svc_w[w] = sel && (reg_wdata != '0) && (reg_wdata != '1);
        assign words_nxt[w*WORD_W +: WORD_W] =
            (words_o[w*WORD_W +: WORD_W] & ~clr_mask) | set_mask;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                words_o[w*WORD_W +: WORD_W] <= '0;
            end else begin
                words_o[w*WORD_W +: WORD_W] <= words_nxt[w*WORD_W +: WORD_W];
            end
        end
    end

    assign serviced_empty_o = (|svc_w) && (words_nxt == '0);

    // R10: an out-of-range vector never lands in the status words
    a_r10_drop_no_set: assert property (@(posedge clk) disable iff (!rst_n)
        drop_o && !reg_wr |=> $stable(words_o));
    // R4: a zero clear mask is a no-op
    a_r4_zero_noop: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && (reg_wdata == '0) && !msi_valid |=> $stable(words_o));
    // R1, R2: the accepted vector's bit is set
    a_r1_vector_set: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |=> words_o[$past(vec_idx)]);
endmodule

// File: rtl/pcie_irq_intx.sv
module pcie_irq_intx
    import pcie_irq_pkg::*;
#(
    parameter int unsigned PINS   = INTX_PINS,
    parameter int unsigned REG_AW = 2,
    localparam int unsigned STS_W = PINS + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PINS-1:0]   intx_pin,
    input  logic              txn_done,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [STS_W-1:0]  reg_wdata,
    output logic [STS_W-1:0]  en_o,
    output logic [STS_W-1:0]  sts_o,
    output logic              chg_o,
    output logic              active_o
);
    logic             wr_en;
    logic             wr_sts;
    logic [STS_W-1:0] en_nxt;
    logic             done_nxt;

    assign wr_en  = reg_wr && (reg_addr == REG_AW'(0));
    assign wr_sts = reg_wr && (reg_addr == REG_AW'(1));
    assign en_nxt = wr_en ? reg_wdata : en_o;
    assign chg_o  = (intx_pin != sts_o[PINS-1:0]);

    always_comb begin
        done_nxt = sts_o[PINS];
        if (txn_done) begin
            done_nxt = 1'b1;
        end else if (wr_sts && reg_wdata[PINS]) begin
            done_nxt = 1'b0;
        end
    end

    assign active_o = |({done_nxt, intx_pin} & en_nxt);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_o  <= '0;
            sts_o <= '0;
        end else begin
            en_o  <= en_nxt;
            sts_o <= {done_nxt, intx_pin};
        end
    end

    // R7: level bits track the pins with one register stage
    a_r7_follow: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> sts_o[PINS-1:0] == $past(intx_pin));
    // R9: a done pulse always sets the flag
    a_r9_done_set: assert property (@(posedge clk) disable iff (!rst_n)
        txn_done |=> sts_o[PINS]);
endmodule

// File: rtl/pcie_irq_line_fsm.sv
module pcie_irq_line_fsm
    import pcie_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic msi_hit,
    input  logic serviced_empty,
    input  logic intx_chg,
    input  logic intx_active,
    output logic irq_o
);
    line_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LINE_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LINE_LOW: begin
                if (msi_hit) begin
                    state_d = LINE_HIGH;
                end else if (!serviced_empty && intx_chg && intx_active) begin
                    state_d = LINE_HIGH;
                end
            end
            LINE_HIGH: begin
                if (msi_hit) begin
                    state_d = LINE_HIGH;
                end else if (serviced_empty) begin
                    state_d = LINE_LOW;
                end else if (intx_chg && !intx_active) begin
                    state_d = LINE_LOW;
                end
            end
            default: state_d = LINE_LOW;
        endcase
    end

    always_comb begin
        irq_o = (state_q == LINE_HIGH);
    end

    // R3: an accepted MSI always raises the line
    a_r3_raise: assert property (@(posedge clk) disable iff (!rst_n)
        msi_hit |=> irq_o);
    // R6: an emptying service clear lowers the line unless an MSI arrives
    a_r6_lower: assert property (@(posedge clk) disable iff (!rst_n)
        serviced_empty && !msi_hit |=> !irq_o);
    // R8: without an event the line holds
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !msi_hit && !serviced_empty && !intx_chg |=> $stable(irq_o));
endmodule

// File: rtl/pcie_irq_aggr.sv
module pcie_irq_aggr
    import pcie_irq_pkg::*;
#(
    parameter int unsigned NUM_VEC = 64,
    parameter int unsigned DATA_W  = 32,
    localparam int unsigned NUM_WORDS = NUM_VEC / WORD_W,
    localparam int unsigned REG_AW    = $clog2(2 + NUM_WORDS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [INTX_PINS-1:0] intx_pin,
    input  logic                 txn_done,
    input  logic                 msi_valid,
    input  logic [DATA_W-1:0]    msi_data,
    input  logic                 reg_wr,
    input  logic [REG_AW-1:0]    reg_addr,
    input  logic [WORD_W-1:0]    reg_wdata,
    output logic [WORD_W-1:0]    reg_rdata,
    output logic                 irq,
    output logic                 msi_err
);
    logic [NUM_WORDS*WORD_W-1:0] words;
    logic                        msi_hit;
    logic                        msi_drop;
    logic                        serviced_empty;
    logic [ISTS_W-1:0]           intx_en;
    logic [ISTS_W-1:0]           intx_sts;
    logic                        intx_chg;
    logic                        intx_active;

    pcie_irq_msi_bank #(
        .NUM_VEC (NUM_VEC),
        .DATA_W  (DATA_W),
        .REG_AW  (REG_AW),
        .BASE    (2)
    ) u_msi (
        .clk              (clk),
        .rst_n            (rst_n),
        .msi_valid        (msi_valid),
        .msi_data         (msi_data),
        .reg_wr           (reg_wr),
        .reg_addr         (reg_addr),
        .reg_wdata        (reg_wdata),
        .words_o          (words),
        .hit_o            (msi_hit),
        .drop_o           (msi_drop),
        .serviced_empty_o (serviced_empty)
    );

    pcie_irq_intx #(
        .PINS   (INTX_PINS),
        .REG_AW (REG_AW)
    ) u_intx (
        .clk       (clk),
        .rst_n     (rst_n),
        .intx_pin  (intx_pin),
        .txn_done  (txn_done),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata[ISTS_W-1:0]),
        .en_o      (intx_en),
        .sts_o     (intx_sts),
        .chg_o     (intx_chg),
        .active_o  (intx_active)
    );

    pcie_irq_line_fsm u_line (
        .clk            (clk),
        .rst_n          (rst_n),
        .msi_hit        (msi_hit),
        .serviced_empty (serviced_empty),
        .intx_chg       (intx_chg),
        .intx_active    (intx_active),
        .irq_o          (irq)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msi_err <= 1'b0;
        end else begin
            msi_err <= msi_drop;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == REG_AW'(0)) begin
            reg_rdata = WORD_W'(intx_en);
        end else if (reg_addr == REG_AW'(1)) begin
            reg_rdata = WORD_W'(intx_sts);
        end
        for (int w = 0; w < int'(NUM_WORDS); w++) begin
            if (reg_addr == REG_AW'(2 + w)) begin
                reg_rdata = words[w*WORD_W +: WORD_W];
            end
        end
    end

    // R10: a dropped vector is flagged in the next cycle
    a_r10_err_flag: assert property (@(posedge clk) disable iff (!rst_n)
        msi_drop |=> msi_err);
    // R5: an all-ones clear alone leaves the line as it was
    a_r5_init_hold: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && (reg_addr >= REG_AW'(2)) && (reg_wdata == '1)
        && !msi_valid && !intx_chg |=> $stable(irq));
endmodule

// File: tb/pcie_irq_aggr_tb.sv
module pcie_irq_aggr_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  intx_pin = '0;
    logic        txn_done = 1'b0;
    logic        msi_valid = 1'b0;
    logic [31:0] msi_data = '0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;
    logic        msi_err;

    int checks = 0;
    int failures = 0;
    bit done_flag = 0;

    logic [31:0] m_w0, m_w1;
    logic [4:0]  m_en;
    logic [3:0]  m_pins;
    logic        m_done, m_irq, m_err;

    always #5 clk = ~clk;

    pcie_irq_aggr dut_i (
        .clk(clk), .rst_n(rst_n), .intx_pin(intx_pin), .txn_done(txn_done),
        .msi_valid(msi_valid), .msi_data(msi_data), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .msi_err(msi_err)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] model_reg(input int a);
        case (a)
            0: return {27'd0, m_en};
            1: return {27'd0, m_done, m_pins};
            2: return m_w0;
            default: return m_w1;
        endcase
    endfunction

    task automatic check_all(input string tag);
        check(tag, "irq", {31'd0, irq}, {31'd0, m_irq});
        check(tag, "msi_err", {31'd0, msi_err}, {31'd0, m_err});
        for (int a = 0; a < 4; a++) begin
            reg_addr = 2'(a);
            #1;
            check(tag, $sformatf("reg%0d", a), reg_rdata, model_reg(a));
        end
    endtask

    task automatic cycle(input string tag, input logic [3:0] pins, input logic dn,
                         input logic mv, input logic [31:0] md,
                         input logic wr, input logic [1:0] a, input logic [31:0] wd);
        logic [31:0] n0, n1;
        logic [4:0]  en_n;
        logic        done_n, chg, hit, svc;
        @(negedge clk);
        intx_pin = pins; txn_done = dn; msi_valid = mv; msi_data = md;
        reg_wr = wr; reg_addr = a; reg_wdata = wd;
        chg    = (pins != m_pins);
        en_n   = (wr && a == 2'd0) ? wd[4:0] : m_en;
        done_n = m_done;
        if (dn) done_n = 1'b1;
        else if (wr && a == 2'd1 && wd[4]) done_n = 1'b0;
        n0 = m_w0; n1 = m_w1;
        if (wr && a == 2'd2) n0 = n0 & ~wd;
        if (wr && a == 2'd3) n1 = n1 & ~wd;
        hit = mv && (md < 64);
        if (hit && md < 32) n0 = n0 | (32'd1 << md[4:0]);
        if (hit && md >= 32) n1 = n1 | (32'd1 << md[4:0]);
        svc = wr && a[1] && (wd != 32'd0) && (wd != 32'hFFFF_FFFF);
        if (hit) m_irq = 1'b1;
        else if (svc && n0 == 0 && n1 == 0) m_irq = 1'b0;
        else if (chg) m_irq = |({done_n, pins} & en_n);
        m_err = mv && (md >= 64);
        m_w0 = n0; m_w1 = n1; m_en = en_n; m_done = done_n; m_pins = pins;
        @(posedge clk);
        #2;
        reg_wr = 1'b0; msi_valid = 1'b0; txn_done = 1'b0;
        check_all(tag);
    endtask

    initial begin
        #2_000_000;
        if (!done_flag) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed;
        seed = $urandom(32'd1234);
        m_w0 = 0; m_w1 = 0; m_en = 0; m_pins = 0; m_done = 0; m_irq = 0; m_err = 0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        #1 check_all("R11");

        // R1 / R3: low vector
        cycle("R1", 4'h0, 0, 1, 32'd5, 0, 2'd0, 0);
        // R2: high vector
        cycle("R2", 4'h0, 0, 1, 32'd40, 0, 2'd0, 0);
        // R4: zero write has no effect
        cycle("R4", 4'h0, 0, 0, 0, 1, 2'd2, 32'd0);
        // R6: partial service, other word still set -> line stays
        cycle("R6", 4'h0, 0, 0, 0, 1, 2'd2, 32'h20);
        // R5: init clear empties word, line stays high
        cycle("R5", 4'h0, 0, 0, 0, 1, 2'd3, 32'hFFFF_FFFF);
        // R6: vector 63 then service to empty lowers the line
        cycle("R3", 4'h0, 0, 1, 32'd63, 0, 2'd0, 0);
        cycle("R6", 4'h0, 0, 0, 0, 1, 2'd3, 32'h8000_0000);
        // R10: out-of-range vectors
        cycle("R10", 4'h0, 0, 1, 32'd64, 0, 2'd0, 0);
        cycle("R10", 4'h0, 0, 1, 32'hFFFF_FFFF, 0, 2'd0, 0);
        // R8: enable write alone keeps line; pin edges re-evaluate
        cycle("R8", 4'h0, 0, 0, 0, 1, 2'd0, 32'h1);
        cycle("R8", 4'h1, 0, 0, 0, 0, 2'd0, 0);
        cycle("R7", 4'h1, 0, 0, 0, 0, 2'd0, 0);
        // R9: software cannot clear level bits; done flag set/clear
        cycle("R9", 4'h1, 0, 0, 0, 1, 2'd1, 32'hFFFF_FFFF);
        cycle("R9", 4'h1, 1, 0, 0, 0, 2'd0, 0);
        cycle("R9", 4'h1, 1, 0, 0, 1, 2'd1, 32'h10);
        cycle("R9", 4'h1, 0, 0, 0, 1, 2'd1, 32'h10);
        cycle("R8", 4'h0, 0, 0, 0, 0, 2'd0, 0);
        // R12: MSI set beats same-word clear and lowering
        cycle("R12", 4'h0, 0, 1, 32'd3, 1, 2'd2, 32'hFFFF_FFFF);
        cycle("R12", 4'h0, 0, 1, 32'd4, 1, 2'd2, 32'h8);
        // R12: emptying service beats an INTx rise
        cycle("R12", 4'h1, 0, 0, 0, 1, 2'd2, 32'h10);
        cycle("R12", 4'h0, 0, 0, 0, 1, 2'd0, 32'hFFFF_FFE0);

        for (int i = 0; i < 4000; i++) begin
            logic [31:0] wd;
            logic [1:0]  a;
            logic [3:0]  p;
            int k;
            k = int'($urandom_range(0, 5));
            case (k)
                0: wd = 32'd0;
                1: wd = 32'hFFFF_FFFF;
                2, 3: wd = 32'd1 << $urandom_range(0, 31);
                default: wd = $urandom;
            endcase
            a = 2'($urandom_range(0, 3));
            p = ($urandom_range(0, 3) == 0) ? 4'($urandom) : m_pins;
            cycle("R12", p, ($urandom_range(0, 7) == 0),
                  ($urandom_range(0, 2) == 0), 32'($urandom_range(0, 79)),
                  ($urandom_range(0, 1) == 1), a, wd);
        end

        done_flag = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule